// File: doc/BRIEF.md
# DMA Channel Control Register File

This block is the register bank that software uses to drive a small memory-to-memory DMA controller with several channels. Each channel keeps a control word, a staged descriptor (configuration, byte count, destination address, source address) that software fills in, and a read-only execution copy of the descriptor that is currently in flight. The bank does not move data. When a transfer may start, it copies the staged descriptor into the execution copy and gives the transfer engine a one-cycle start pulse. It then waits for the engine to report completion or failure, and raises per-channel done and error interrupt lines.

Before a channel acts on its run bit, software must own the channel by setting its claim bit. Gaining ownership wipes the staged descriptor and loads a default size of 6 into both size fields. Ownership cannot be given up while a transfer runs. Two cases are settled inside the bank without starting the engine: a zero byte count completes at once, and unequal read and write sizes fail at once.

Each channel runs a three-state machine. `CH_IDLE` waits for a control write. The transition *launch* (a claimed run request with a non-zero count and matching sizes) moves it to `CH_LAUNCH`, which holds the start pulse for one cycle. The transition *issue* always follows to `CH_BUSY`. From `CH_BUSY`, the transitions *finish* (engine done) and *fail* (engine error) return to `CH_IDLE`. The immediate outcomes (*zero-count complete*, *size-mismatch fail*, *run refused*) keep the channel in `CH_IDLE`.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every register of every channel reads 0, all interrupt lines are low and no start pulse is given.
- R2: The control word keeps only bit 0 (claim), bit 1 (run), bit 14 (done interrupt enable), bit 15 (error interrupt enable), bit 30 (done flag) and bit 31 (error flag). All other bits read as 0.
- R3: A control write that sets claim on an unclaimed channel loads the staged config with 0x6600_0000 (read size bits 31:28 = 6, write size bits 27:24 = 6) and clears the staged count, destination and source.
- R4: The staged registers are readable and writable. They sit at config 0x004, count 0x008/0x00C, destination 0x010/0x014 and source 0x018/0x01C, with the low word of each 64-bit value first.
- R5: A run request is refused (run reads 0, no start pulse) if the channel was unclaimed before the write, or if the write drops claim while run is low.
- R6: A claimed run request with a non-zero count and equal sizes copies the staged descriptor into the execution copy and clears both flags. It raises that channel's start pulse for exactly the one cycle after the write. Run then reads 1 until the engine reports, and at most one channel starts per cycle.
- R7: An engine done report clears run and sets the done flag. An engine error report clears run and sets the error flag.
- R8: While a transfer is in flight, a control write that clears claim or run leaves both bits set.
- R9: A run request with a zero staged count sets the done flag and clears run without a start pulse.
- R10: A run request whose read size differs from its write size sets the error flag and clears run without a start pulse.
- R11: The execution copy at 0x104 (config), 0x108/0x10C (count), 0x110/0x114 (destination) and 0x118/0x11C (source) ignores bus writes and changes only at a launch.
- R12: The channel number is address bits above bit 11. A channel number at or above the channel count reads 0 and ignores writes, and an unmapped offset reads 0.
- R13: Interrupt line 2·ch is high exactly when channel ch has both the done flag and the done enable set. Line 2·ch+1 does the same for the error flag and the error enable.
- R14: A read request returns its data with a response valid exactly one cycle later, and no response appears without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address: channel number above bit 11, register offset below |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| eng_start | output | NUM_CH | One-cycle start pulse per channel |
| eng_done | input | NUM_CH | Engine completion report per channel |
| eng_err | input | NUM_CH | Engine failure report per channel |
| exec_cfg | output | 32·NUM_CH | Execution config per channel |
| exec_bytes | output | 64·NUM_CH | Execution byte count per channel |
| exec_dst | output | 64·NUM_CH | Execution destination per channel |
| exec_src | output | 64·NUM_CH | Execution source per channel |
| irq | output | 2·NUM_CH | Done (even) and error (odd) interrupt lines |

## Verification
On every cycle, the assertions check the port-level timing rules: start pulses last one cycle, no two channels start in the same cycle, the execution copy moves only with a start pulse, read responses follow reads by one cycle, and out-of-range channels read zero. The claim and run handshake cannot be seen from the ports alone, and neither can the claim-time descriptor reset, the immediate zero-count and size-mismatch outcomes, the effect of the interrupt enables, or the masking of reserved control bits. Only the bench scenarios show these, by reading registers back and watching the interrupt lines after each step.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;

    localparam int DATA_W = 32;
    localparam int OFS_W  = 12;

    localparam int B_CLAIM   = 0;
    localparam int B_RUN     = 1;
    localparam int B_DONE_IE = 14;
    localparam int B_ERR_IE  = 15;
    localparam int B_DONE    = 30;
    localparam int B_ERR     = 31;

    localparam logic [DATA_W-1:0] CTL_KEEP =
        (32'd1 << B_CLAIM) | (32'd1 << B_RUN) | (32'd1 << B_DONE_IE) |
        (32'd1 << B_ERR_IE) | (32'd1 << B_DONE) | (32'd1 << B_ERR);

    localparam int WSZ_LSB = 24;
    localparam int RSZ_LSB = 28;
    localparam int SZ_W    = 4;
    localparam logic [SZ_W-1:0] SZ_DEFAULT = 4'd6;
    localparam logic [DATA_W-1:0] CFG_ON_CLAIM =
        (DATA_W'(SZ_DEFAULT) << RSZ_LSB) | (DATA_W'(SZ_DEFAULT) << WSZ_LSB);

    typedef enum logic [4:0] {
        SEL_NONE,
        SEL_CTRL,
        SEL_NCFG,
        SEL_NBYTES_LO, SEL_NBYTES_HI,
        SEL_NDST_LO,   SEL_NDST_HI,
        SEL_NSRC_LO,   SEL_NSRC_HI,
        SEL_XCFG,
        SEL_XBYTES_LO, SEL_XBYTES_HI,
        SEL_XDST_LO,   SEL_XDST_HI,
        SEL_XSRC_LO,   SEL_XSRC_HI
    } reg_sel_e;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_LAUNCH,
        CH_BUSY
    } ch_state_e;

    function automatic reg_sel_e map_offset(input logic [OFS_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            12'h000: s = SEL_CTRL;
            12'h004: s = SEL_NCFG;
            12'h008: s = SEL_NBYTES_LO;
            12'h00C: s = SEL_NBYTES_HI;
            12'h010: s = SEL_NDST_LO;
            12'h014: s = SEL_NDST_HI;
            12'h018: s = SEL_NSRC_LO;
            12'h01C: s = SEL_NSRC_HI;
            12'h104: s = SEL_XCFG;
            12'h108: s = SEL_XBYTES_LO;
            12'h10C: s = SEL_XBYTES_HI;
            12'h110: s = SEL_XDST_LO;
            12'h114: s = SEL_XDST_HI;
            12'h118: s = SEL_XSRC_LO;
            12'h11C: s = SEL_XSRC_HI;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic [63:0] put_half(input logic [63:0] old,
                                             input logic hi,
                                             input logic [DATA_W-1:0] d);
        return hi ? {d, old[31:0]} : {old[63:32], d};
    endfunction

endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16,
    localparam int CHF_W = ADDR_W - OFS_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [CHF_W-1:0]  ch_idx,
    output logic              ch_ok,
    output reg_sel_e          sel
);

    always_comb begin
        ch_idx = addr[ADDR_W-1:OFS_W];
        ch_ok  = (32'(ch_idx) < 32'(NUM_CH));
        sel    = map_offset(addr[OFS_W-1:0]);
    end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_rf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rd_word,
    input  logic              eng_done,
    input  logic              eng_err,
    output logic              eng_start,
    output logic              irq_done,
    output logic              irq_err,
    output logic [DATA_W-1:0] xcfg,
    output logic [63:0]       xbytes,
    output logic [63:0]       xdst,
    output logic [63:0]       xsrc
);

    ch_state_e         state_q, state_d;
    logic [DATA_W-1:0] ctrl_q, ctrl_d;
    logic [DATA_W-1:0] ncfg_q, ncfg_d;
    logic [63:0]       nbytes_q, nbytes_d;
    logic [63:0]       ndst_q, ndst_d;
    logic [63:0]       nsrc_q, nsrc_d;
    logic [DATA_W-1:0] xcfg_q, xcfg_d;
    logic [63:0]       xbytes_q, xbytes_d;
    logic [63:0]       xdst_q, xdst_d;
    logic [63:0]       xsrc_q, xsrc_d;

    logic              ctl_wr;
    logic [DATA_W-1:0] v;
    logic              size_clash;

    assign ctl_wr     = wr_en && (sel == SEL_CTRL);
    assign size_clash = ncfg_q[WSZ_LSB +: SZ_W] != ncfg_q[RSZ_LSB +: SZ_W];

    // state register and storage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= CH_IDLE;
            ctrl_q   <= '0;
            ncfg_q   <= '0;
            nbytes_q <= '0;
            ndst_q   <= '0;
            nsrc_q   <= '0;
            xcfg_q   <= '0;
            xbytes_q <= '0;
            xdst_q   <= '0;
            xsrc_q   <= '0;
        end else begin
            state_q  <= state_d;
            ctrl_q   <= ctrl_d;
            ncfg_q   <= ncfg_d;
            nbytes_q <= nbytes_d;
            ndst_q   <= ndst_d;
            nsrc_q   <= nsrc_d;
            xcfg_q   <= xcfg_d;
            xbytes_q <= xbytes_d;
            xdst_q   <= xdst_d;
            xsrc_q   <= xsrc_d;
        end
    end

    // transitions and register updates
    always_comb begin
        state_d  = state_q;
        ctrl_d   = ctrl_q;
        ncfg_d   = ncfg_q;
        nbytes_d = nbytes_q;
        ndst_d   = ndst_q;
        nsrc_d   = nsrc_q;
        xcfg_d   = xcfg_q;
        xbytes_d = xbytes_q;
        xdst_d   = xdst_q;
        xsrc_d   = xsrc_q;
        v        = wdata & CTL_KEEP;

        // staged descriptor writes, accepted in every state
        if (wr_en) begin
            case (sel)
                SEL_NCFG:      ncfg_d   = wdata;
                SEL_NBYTES_LO: nbytes_d = put_half(nbytes_q, 1'b0, wdata);
                SEL_NBYTES_HI: nbytes_d = put_half(nbytes_q, 1'b1, wdata);
                SEL_NDST_LO:   ndst_d   = put_half(ndst_q, 1'b0, wdata);
                SEL_NDST_HI:   ndst_d   = put_half(ndst_q, 1'b1, wdata);
                SEL_NSRC_LO:   nsrc_d   = put_half(nsrc_q, 1'b0, wdata);
                SEL_NSRC_HI:   nsrc_d   = put_half(nsrc_q, 1'b1, wdata);
                default: ;
            endcase
        end

        unique case (state_q)
            CH_IDLE: begin
                if (ctl_wr) begin
                    // gaining the claim wipes the staged descriptor
                    if (!ctrl_q[B_CLAIM] && v[B_CLAIM]) begin
                        ncfg_d   = CFG_ON_CLAIM;
                        nbytes_d = '0;
                        ndst_d   = '0;
                        nsrc_d   = '0;
                    end
                    if (ctrl_q[B_RUN] && !v[B_CLAIM]) begin
                        v[B_CLAIM] = 1'b1;
                    end
                    if (!ctrl_q[B_CLAIM] || (!ctrl_q[B_RUN] && !v[B_CLAIM])) begin
                        // run refused
                        v[B_RUN] = 1'b0;
                    end else if (v[B_RUN]) begin
                        if (nbytes_q == '0) begin
                            // zero-count complete
                            v[B_RUN]  = 1'b0;
                            v[B_DONE] = 1'b1;
                        end else if (size_clash) begin
                            // size-mismatch fail
                            v[B_RUN] = 1'b0;
                            v[B_ERR] = 1'b1;
                        end else begin
                            // launch
                            v[B_DONE] = 1'b0;
                            v[B_ERR]  = 1'b0;
                            xcfg_d    = ncfg_q;
                            xbytes_d  = nbytes_q;
                            xdst_d    = ndst_q;
                            xsrc_d    = nsrc_q;
                            state_d   = CH_LAUNCH;
                        end
                    end
                    ctrl_d = v;
                end
            end
            CH_LAUNCH: begin
                if (ctl_wr) begin
                    v[B_CLAIM] = 1'b1;
                    v[B_RUN]   = 1'b1;
                    ctrl_d     = v;
                end
                // issue
                state_d = CH_BUSY;
            end
            CH_BUSY: begin
                if (ctl_wr) begin
                    v[B_CLAIM] = 1'b1;
                    v[B_RUN]   = 1'b1;
                    ctrl_d     = v;
                end
                if (eng_err) begin
                    // fail
                    ctrl_d[B_RUN] = 1'b0;
                    ctrl_d[B_ERR] = 1'b1;
                    state_d       = CH_IDLE;
                end else if (eng_done) begin
                    // finish
                    ctrl_d[B_RUN]  = 1'b0;
                    ctrl_d[B_DONE] = 1'b1;
                    state_d        = CH_IDLE;
                end
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        eng_start = (state_q == CH_LAUNCH);
        irq_done  = ctrl_q[B_DONE] && ctrl_q[B_DONE_IE];
        irq_err   = ctrl_q[B_ERR] && ctrl_q[B_ERR_IE];
        xcfg      = xcfg_q;
        xbytes    = xbytes_q;
        xdst      = xdst_q;
        xsrc      = xsrc_q;
        unique case (sel)
            SEL_CTRL:      rd_word = ctrl_q;
            SEL_NCFG:      rd_word = ncfg_q;
            SEL_NBYTES_LO: rd_word = nbytes_q[31:0];
            SEL_NBYTES_HI: rd_word = nbytes_q[63:32];
            SEL_NDST_LO:   rd_word = ndst_q[31:0];
            SEL_NDST_HI:   rd_word = ndst_q[63:32];
            SEL_NSRC_LO:   rd_word = nsrc_q[31:0];
            SEL_NSRC_HI:   rd_word = nsrc_q[63:32];
            SEL_XCFG:      rd_word = xcfg_q;
            SEL_XBYTES_LO: rd_word = xbytes_q[31:0];
            SEL_XBYTES_HI: rd_word = xbytes_q[63:32];
            SEL_XDST_LO:   rd_word = xdst_q[31:0];
            SEL_XDST_HI:   rd_word = xdst_q[63:32];
            SEL_XSRC_LO:   rd_word = xsrc_q[31:0];
            SEL_XSRC_HI:   rd_word = xsrc_q[63:32];
            default:       rd_word = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
    import dma_rf_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    output logic [NUM_CH-1:0]      eng_start,
    input  logic [NUM_CH-1:0]      eng_done,
    input  logic [NUM_CH-1:0]      eng_err,
    output logic [NUM_CH*32-1:0]   exec_cfg,
    output logic [NUM_CH*64-1:0]   exec_bytes,
    output logic [NUM_CH*64-1:0]   exec_dst,
    output logic [NUM_CH*64-1:0]   exec_src,
    output logic [2*NUM_CH-1:0]    irq
);

    localparam int CHF_W = ADDR_W - OFS_W;

    logic [CHF_W-1:0]  ch_idx;
    logic              ch_ok;
    reg_sel_e          sel;
    logic [DATA_W-1:0] rd_words [NUM_CH];
    logic [DATA_W-1:0] rd_mux;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    dma_addr_decode #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr   (req_addr),
        .ch_idx (ch_idx),
        .ch_ok  (ch_ok),
        .sel    (sel)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic hit_wr;
        assign hit_wr = req_valid && req_write && ch_ok && (ch_idx == CHF_W'(i));

        dma_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (hit_wr),
            .sel       (sel),
            .wdata     (req_wdata),
            .rd_word   (rd_words[i]),
            .eng_done  (eng_done[i]),
            .eng_err   (eng_err[i]),
            .eng_start (eng_start[i]),
            .irq_done  (irq[2*i]),
            .irq_err   (irq[2*i+1]),
            .xcfg      (exec_cfg[i*32 +: 32]),
            .xbytes    (exec_bytes[i*64 +: 64]),
            .xdst      (exec_dst[i*64 +: 64]),
            .xsrc      (exec_src[i*64 +: 64])
        );
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (ch_ok && (ch_idx == CHF_W'(i))) rd_mux = rd_words[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= req_valid && !req_write;
            rsp_rdata_q <= (req_valid && !req_write) ? rd_mux : '0;
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

endmodule

// File: rtl/dma_chan_regfile_chk.sv
module dma_chan_regfile_chk #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic                 req_write,
    input logic [ADDR_W-1:0]    req_addr,
    input logic                 rsp_valid,
    input logic [31:0]          rsp_rdata,
    input logic [NUM_CH-1:0]    eng_start,
    input logic [NUM_CH*32-1:0] exec_cfg,
    input logic [NUM_CH*64-1:0] exec_bytes,
    input logic [NUM_CH*64-1:0] exec_dst,
    input logic [NUM_CH*64-1:0] exec_src
);

    logic is_read;
    logic far_ch;
    assign is_read = req_valid && !req_write;
    assign far_ch  = 32'(req_addr[ADDR_W-1:12]) >= 32'(NUM_CH);

    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_start != '0) |=> ((eng_start & $past(eng_start)) == '0)); // R6

    AST_SINGLE_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(eng_start)); // R6

    AST_EXEC_MOVES_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({exec_cfg, exec_bytes, exec_dst, exec_src}) |-> (eng_start != '0)); // R11

    AST_READ_GETS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        is_read |=> rsp_valid); // R14

    AST_NO_STRAY_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !is_read |=> !rsp_valid); // R14

    AST_FAR_CH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (is_read && far_ch) |=> (rsp_rdata == '0)); // R12

endmodule

bind dma_chan_regfile dma_chan_regfile_chk #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .eng_start  (eng_start),
    .exec_cfg   (exec_cfg),
    .exec_bytes (exec_bytes),
    .exec_dst   (exec_dst),
    .exec_src   (exec_src)
);

// File: tb/dma_chan_regfile_test.sv
module dma_chan_regfile_test;

    localparam int NUM_CH = 4;
    localparam int ADDR_W = 16;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [ADDR_W-1:0]      req_addr = '0;
    logic [31:0]            req_wdata = '0;
    logic                   rsp_valid;
    logic [31:0]            rsp_rdata;
    logic [NUM_CH-1:0]      eng_start;
    logic [NUM_CH-1:0]      eng_done = '0;
    logic [NUM_CH-1:0]      eng_err = '0;
    logic [NUM_CH*32-1:0]   exec_cfg;
    logic [NUM_CH*64-1:0]   exec_bytes;
    logic [NUM_CH*64-1:0]   exec_dst;
    logic [NUM_CH*64-1:0]   exec_src;
    logic [2*NUM_CH-1:0]    irq;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    dma_chan_regfile #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .eng_start(eng_start), .eng_done(eng_done),
        .eng_err(eng_err), .exec_cfg(exec_cfg), .exec_bytes(exec_bytes),
        .exec_dst(exec_dst), .exec_src(exec_src), .irq(irq)
    );

    function automatic logic [ADDR_W-1:0] ra(input int ch, input logic [11:0] ofs);
        return {4'(ch), ofs};
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // driver: issues a read and queues the expected response
    task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic engine(input int ch, input bit err);
        @(negedge clk);
        if (err) eng_err[ch] = 1'b1; else eng_done[ch] = 1'b1;
        @(negedge clk);
        eng_err = '0; eng_done = '0;
    endtask

    // monitor: compares each response against the queued expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R14 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                check(tag_q.pop_front(), {32'h0, rsp_rdata}, {32'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL R14 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {56'h0, irq}, 64'h0);
        check("R1 start", {60'h0, eng_start}, 64'h0);
        rd(ra(0, 12'h000), 32'h0, "R1 ctrl ch0");
        rd(ra(1, 12'h004), 32'h0, "R1 ncfg ch1");

        // R3 claim wipes staged descriptor; R5 run on unclaimed refused
        wr(ra(0, 12'h008), 32'h55);
        wr(ra(0, 12'h014), 32'h77);
        wr(ra(0, 12'h000), 32'h3);
        check("R5 no start unclaimed", {60'h0, eng_start}, 64'h0);
        rd(ra(0, 12'h000), 32'h1, "R5 run cleared");
        rd(ra(0, 12'h004), 32'h6600_0000, "R3 default cfg");
        rd(ra(0, 12'h008), 32'h0, "R3 bytes cleared");
        rd(ra(0, 12'h014), 32'h0, "R3 dst cleared");

        // R4 staged registers
        wr(ra(0, 12'h008), 32'h100);
        wr(ra(0, 12'h00C), 32'h1);
        wr(ra(0, 12'h010), 32'h8000_0000);
        wr(ra(0, 12'h014), 32'h2);
        wr(ra(0, 12'h018), 32'h4000);
        wr(ra(0, 12'h004), 32'h6600_000C);
        rd(ra(0, 12'h00C), 32'h1, "R4 bytes hi");
        rd(ra(0, 12'h010), 32'h8000_0000, "R4 dst lo");
        rd(ra(0, 12'h018), 32'h4000, "R4 src lo");
        rd(ra(0, 12'h004), 32'h6600_000C, "R4 cfg");

        // R2 bit storage and R13 interrupts
        wr(ra(0, 12'h000), 32'hC000_C001);
        rd(ra(0, 12'h000), 32'hC000_C001, "R2 flags stored");
        check("R13 both lines ch0", {56'h0, irq}, 64'h3);
        wr(ra(0, 12'h000), 32'h3FFF_3FFD);
        rd(ra(0, 12'h000), 32'h1, "R2 reserved dropped");
        check("R13 enables off", {56'h0, irq}, 64'h0);

        // R6 launch
        wr(ra(0, 12'h000), 32'h0000_C003);
        check("R6 start pulse", {60'h0, eng_start}, 64'h1);
        check("R6 exec bytes", exec_bytes[63:0], 64'h1_0000_0100);
        check("R6 exec dst", exec_dst[63:0], 64'h2_8000_0000);
        check("R6 exec cfg", {32'h0, exec_cfg[31:0]}, {32'h0, 32'h6600_000C});
        @(negedge clk);
        check("R6 pulse ends", {60'h0, eng_start}, 64'h0);
        rd(ra(0, 12'h108), 32'h100, "R6 exec bytes via bus");
        rd(ra(0, 12'h000), 32'h0000_C003, "R6 run held");

        // R8 claim and run held while busy; R11 exec write ignored
        wr(ra(0, 12'h000), 32'h0000_C000);
        rd(ra(0, 12'h000), 32'h0000_C003, "R8 claim held");
        wr(ra(0, 12'h108), 32'hDEAD);
        rd(ra(0, 12'h108), 32'h100, "R11 exec write ignored");

        // R7 finish
        engine(0, 1'b0);
        rd(ra(0, 12'h000), 32'h4000_C001, "R7 done");
        check("R13 done line", {56'h0, irq}, 64'h1);

        // R7 fail after relaunch
        wr(ra(0, 12'h000), 32'h0000_C003);
        check("R6 relaunch start", {60'h0, eng_start}, 64'h1);
        check("R13 flags cleared", {56'h0, irq}, 64'h0);
        engine(0, 1'b1);
        rd(ra(0, 12'h000), 32'h8000_C001, "R7 error");
        check("R13 error line", {56'h0, irq}, 64'h2);

        // R9 zero count on ch1
        wr(ra(1, 12'h000), 32'h1);
        wr(ra(1, 12'h000), 32'h4003);
        check("R9 no start", {60'h0, eng_start}, 64'h0);
        rd(ra(1, 12'h000), 32'h4000_4001, "R9 done at once");
        check("R13 ch1 done line", {56'h0, irq}, 64'h6);

        // R10 size mismatch on ch2
        wr(ra(2, 12'h000), 32'h1);
        wr(ra(2, 12'h008), 32'h10);
        wr(ra(2, 12'h004), 32'h5600_0000);
        wr(ra(2, 12'h000), 32'h8003);
        check("R10 no start", {60'h0, eng_start}, 64'h0);
        rd(ra(2, 12'h000), 32'h8000_8001, "R10 error at once");
        check("R13 ch2 error line", {56'h0, irq}, 64'h26);

        // R5 claim dropped with run low
        wr(ra(3, 12'h000), 32'h1);
        wr(ra(3, 12'h008), 32'h20);
        wr(ra(3, 12'h000), 32'h2);
        check("R5 no start on drop", {60'h0, eng_start}, 64'h0);
        rd(ra(3, 12'h000), 32'h0, "R5 run refused on drop");

        // R12 far channel and unmapped offsets
        rd(ra(4, 12'h000), 32'h0, "R12 far ch reads zero");
        wr(ra(4, 12'h008), 32'hAB);
        rd(ra(0, 12'h008), 32'h100, "R12 far write ignored");
        rd(ra(0, 12'h020), 32'h0, "R12 unmapped 0x020");
        rd(ra(0, 12'h100), 32'h0, "R12 unmapped 0x100");

        repeat (3) @(negedge clk);
        check("R14 all responses seen", 64'(exp_q.size()), 64'h0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule